// File: doc/BRIEF.md
# Multi-Slope Integrating ADC Sequencer

This block is the digital sequencer for an integrating analog-to-digital converter. A start pulse begins a conversion with two phases. In the first phase (runup) the input is integrated for a fixed number of ramps. At each ramp boundary the comparator bit selects which reference current is applied for the next ramp, and a signed counter keeps track of the balance. In the second phase (rundown) the residual charge is removed at a fixed reference rate. The clocks needed for the comparator to change state are counted, so the least significant part of the result comes from rundown and the most significant part comes from runup.

Runup length depends on the resolution setting. A short setting uses 34 ramps. The two longer settings use 349 ramps. A ramp lasts 30 clocks, or 36 clocks when the 50 Hz mains option is selected. The finest setting runs ten conversions back to back and sums them into one reading. The integrator, references and comparator are analog parts outside the block; only the comparator bit enters it.

Top module: `msadc_sequencer`

## Requirements
- R1: While reset is asserted, the block behaves as follows: busy, done, overflow, integrator enable and both reference controls are low, reading is zero, and a start pulse has no effect.
- R2: A start pulse with busy low is accepted, and busy is high after that clock edge. The resolution code (digitsSel 00 = short, 01 = medium, 10 = averaging, 11 behaves as medium) and the mains option are captured at acceptance. Later changes to those inputs do not alter the conversion in progress.
- R3: A start pulse while busy is high is ignored. This includes the edge on which the final conversion finishes.
- R4: Runup spans 34 ramps in short mode and 349 ramps otherwise. Each ramp is 30 clocks, or 36 with slow50=1. The integrator enable is high from acceptance until the last runup edge and low during rundown.
- R5: On the first clock of each ramp the comparator is sampled. A 1 drives refDown high (refUp low) for that ramp and adds one to the runup balance. A 0 drives refUp high and subtracts one. The outputs change one cycle after the sampling edge.
- R6: The comparator value at the last runup edge is the residual sign. The matching reference (refDown for sign 1) stays on while the rundown clocks are counted, until the comparator differs from the sign. The count is added for sign 1 and subtracted for sign 0.
- R7: If the comparator has not changed after 64 ramp periods of rundown, rundown ends with a count of 64 times the ramp length and the overflow flag is set. The flag is cleared by the next accepted start. A change exactly on the limit edge is a normal end with no overflow.
- R8: The reading equals the runup balance times the ramp length plus the signed rundown count. Done is a one-cycle pulse in the cycle in which busy falls and the reading is updated. The reading holds until the next done. A single conversion ends N·L + min(D+1, 64·L) edges after acceptance, where N is the ramp count, L the ramp length and D the rundown count.
- R9: In averaging mode, ten conversions run back to back with no idle cycle between them. Their results are summed into one reading, with a single done pulse at the end. The overflow flag is set if any of the ten conversions times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start request, sampled on the clock edge |
| digitsSel | input | 2 | Resolution code |
| slow50 | input | 1 | 50 Hz option: 36-clock ramps |
| cmpIn | input | 1 | Integrator comparator output |
| refUp | output | 1 | Apply the reference that drives the integrator up |
| refDown | output | 1 | Apply the reference that drives the integrator down |
| integEn | output | 1 | Connect the input to the integrator |
| reading | output | READ_W | Signed result, two's complement |
| ovf | output | 1 | Rundown timeout seen in the last reading |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse with a new reading |

## Verification
Two pairs of functions can fall on the same clock edge here.

The first pair is the end of the final conversion and a new start request. The bench raises start exactly on the finishing edge. It then expects done high, busy low, and busy still low one cycle later.

The second pair is a comparator change and the rundown timeout. One vector flips the comparator on the very edge where the limit would be reached, and a neighbouring vector never flips it. Both count and overflow flag are checked against the values the rules predict: 1919 with no overflow, and 1920 with overflow.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RUNUP,
    PH_RUNDN
  } phase_e;

  // strobes from sequencing control to arithmetic datapath
  typedef struct packed {
    logic accClr;    // zero the runup balance
    logic accStep;   // ramp boundary: move balance by one
    logic accUp;     // direction of that move
    logic sumClr;    // zero the multi-conversion sum
    logic convDone;  // a conversion finishes this cycle
    logic rdNeg;     // rundown count is subtracted
    logic publish;   // last conversion: update reading, pulse done
  } seqStrobe_t;

  localparam logic [1:0] DIG_SHORT = 2'b00;
  localparam logic [1:0] DIG_AVG   = 2'b10;

endpackage

// File: rtl/msadc_ctrl.sv
module msadc_ctrl
  import msadc_pkg::*;
#(
  parameter int RAMP_FAST   = 30,
  parameter int RAMP_SLOW   = 36,
  parameter int RUNUP_LONG  = 349,
  parameter int RUNUP_SHORT = 34,
  parameter int AVG_CONV    = 10,
  parameter int RD_RAMPS    = 64,
  parameter int CLK_W       = 6,
  parameter int RAMP_W      = 9,
  parameter int CONV_W      = 4,
  parameter int RD_W        = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [1:0]       digitsSel,
  input  logic             slow50,
  input  logic             cmpIn,
  output logic             busy,
  output logic             integEn,
  output logic             refUp,
  output logic             refDown,
  output logic             ovf,
  output logic [RD_W-1:0]  rdCount,
  output logic [CLK_W-1:0] rampLen,
  output seqStrobe_t       strobe
);

  localparam logic [RD_W-1:0]   LIM_FAST = RD_W'(RD_RAMPS * RAMP_FAST);
  localparam logic [RD_W-1:0]   LIM_SLOW = RD_W'(RD_RAMPS * RAMP_SLOW);
  localparam logic [RAMP_W-1:0] LONG_M1  = RAMP_W'(RUNUP_LONG - 1);
  localparam logic [RAMP_W-1:0] SHORT_M1 = RAMP_W'(RUNUP_SHORT - 1);
  localparam logic [CLK_W-1:0]  LEN_FAST = CLK_W'(RAMP_FAST);
  localparam logic [CLK_W-1:0]  LEN_SLOW = CLK_W'(RAMP_SLOW);

  phase_e              phase;
  logic [CLK_W-1:0]    clkCnt;
  logic [RAMP_W-1:0]   rampCnt;
  logic [RD_W-1:0]     rdCnt;
  logic [RD_W-1:0]     rdLimit;
  logic                rdSign;
  logic                shortSel;
  logic                avgSel;
  logic                slowSel;
  logic                busyR, integR, refUpR, refDnR, ovfR;
  logic                startOk, rampLast, runupLast;
  logic                flipSeen, limitHit, finish, lastConv;

  assign rampLen   = slowSel ? LEN_SLOW : LEN_FAST;
  assign rdLimit   = slowSel ? LIM_SLOW : LIM_FAST;
  assign startOk   = startIn && (phase == PH_IDLE);
  assign rampLast  = (clkCnt == rampLen - CLK_W'(1));
  assign runupLast = (rampCnt == (shortSel ? SHORT_M1 : LONG_M1));
  assign flipSeen  = (cmpIn != rdSign);
  assign limitHit  = !flipSeen && (rdCnt == rdLimit - RD_W'(1));
  assign finish    = (phase == PH_RUNDN) && (flipSeen || limitHit);
  assign rdCount   = limitHit ? rdLimit : rdCnt;

  // conversion counter exists only when averaging is configured
  generate
    if (AVG_CONV > 1) begin : g_avg
      localparam logic [CONV_W-1:0] CONV_M1 = CONV_W'(AVG_CONV - 1);
      logic [CONV_W-1:0] convCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    convCnt <= '0;
        else if (startOk)             convCnt <= '0;
        else if (finish && !lastConv) convCnt <= convCnt + CONV_W'(1);
      end
      assign lastConv = !avgSel || (convCnt == CONV_M1);
    end else begin : g_single
      assign lastConv = 1'b1;
    end
  endgenerate

  always_comb begin
    strobe          = '0;
    strobe.accClr   = startOk || (finish && !lastConv);
    strobe.sumClr   = startOk;
    strobe.accStep  = (phase == PH_RUNUP) && (clkCnt == '0);
    strobe.accUp    = cmpIn;
    strobe.convDone = finish;
    strobe.rdNeg    = !rdSign;
    strobe.publish  = finish && lastConv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      busyR    <= 1'b0;
      integR   <= 1'b0;
      refUpR   <= 1'b0;
      refDnR   <= 1'b0;
      ovfR     <= 1'b0;
      clkCnt   <= '0;
      rampCnt  <= '0;
      rdCnt    <= '0;
      rdSign   <= 1'b0;
      shortSel <= 1'b0;
      avgSel   <= 1'b0;
      slowSel  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (startOk) begin
            shortSel <= (digitsSel == DIG_SHORT);
            avgSel   <= (digitsSel == DIG_AVG);
            slowSel  <= slow50;
            busyR    <= 1'b1;
            integR   <= 1'b1;
            ovfR     <= 1'b0;
            clkCnt   <= '0;
            rampCnt  <= '0;
            phase    <= PH_RUNUP;
          end
        end
        PH_RUNUP: begin
          if (clkCnt == '0) begin
            refDnR <= cmpIn;
            refUpR <= !cmpIn;
          end
          if (rampLast) begin
            clkCnt <= '0;
            if (runupLast) begin
              phase  <= PH_RUNDN;
              integR <= 1'b0;
              rdSign <= cmpIn;
              refDnR <= cmpIn;
              refUpR <= !cmpIn;
              rdCnt  <= '0;
            end else begin
              rampCnt <= rampCnt + RAMP_W'(1);
            end
          end else begin
            clkCnt <= clkCnt + CLK_W'(1);
          end
        end
        PH_RUNDN: begin
          if (finish) begin
            refUpR <= 1'b0;
            refDnR <= 1'b0;
            rdCnt  <= '0;
            if (limitHit) ovfR <= 1'b1;
            if (lastConv) begin
              phase <= PH_IDLE;
              busyR <= 1'b0;
            end else begin
              phase   <= PH_RUNUP;
              integR  <= 1'b1;
              clkCnt  <= '0;
              rampCnt <= '0;
            end
          end else begin
            rdCnt <= rdCnt + RD_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy    = busyR;
  assign integEn = integR;
  assign refUp   = refUpR;
  assign refDown = refDnR;
  assign ovf     = ovfR;

endmodule

// File: rtl/msadc_datapath.sv
module msadc_datapath
  import msadc_pkg::*;
#(
  parameter int CLK_W  = 6,
  parameter int RD_W   = 12,
  parameter int ACC_W  = 10,
  parameter int READ_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [RD_W-1:0]   rdCount,
  input  logic [CLK_W-1:0]  rampLen,
  output logic [READ_W-1:0] reading,
  output logic              done
);

  logic signed [ACC_W-1:0]  acc;
  logic signed [READ_W-1:0] sum, readR;
  logic signed [READ_W-1:0] accExt, lenExt, cntExt, convVal;

  assign accExt  = {{(READ_W-ACC_W){acc[ACC_W-1]}}, acc};
  assign lenExt  = {{(READ_W-CLK_W){1'b0}}, rampLen};
  assign cntExt  = {{(READ_W-RD_W){1'b0}}, rdCount};
  assign convVal = accExt * lenExt + (strobe.rdNeg ? -cntExt : cntExt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc   <= '0;
      sum   <= '0;
      readR <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe.publish;
      if (strobe.accClr)       acc <= '0;
      else if (strobe.accStep) acc <= strobe.accUp ? acc + ACC_W'(1) : acc - ACC_W'(1);
      if (strobe.sumClr) begin
        sum <= '0;
      end else if (strobe.convDone) begin
        if (strobe.publish) begin
          readR <= sum + convVal;
          sum   <= '0;
        end else begin
          sum <= sum + convVal;
        end
      end
    end
  end

  assign reading = readR;

endmodule

// File: rtl/msadc_sequencer.sv
module msadc_sequencer
  import msadc_pkg::*;
#(
  parameter int RAMP_FAST   = 30,
  parameter int RAMP_SLOW   = 36,
  parameter int RUNUP_LONG  = 349,
  parameter int RUNUP_SHORT = 34,
  parameter int AVG_CONV    = 10,
  parameter int RD_RAMPS    = 64,
  parameter int READ_W      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic [1:0]        digitsSel,
  input  logic              slow50,
  input  logic              cmpIn,
  output logic              refUp,
  output logic              refDown,
  output logic              integEn,
  output logic [READ_W-1:0] reading,
  output logic              ovf,
  output logic              busy,
  output logic              done
);

  localparam int RAMP_MAX = (RAMP_SLOW > RAMP_FAST) ? RAMP_SLOW : RAMP_FAST;
  localparam int CLK_W    = $clog2(RAMP_MAX + 1);
  localparam int RAMP_W   = $clog2(RUNUP_LONG + 1);
  localparam int ACC_W    = RAMP_W + 1;
  localparam int CONV_W   = $clog2(AVG_CONV + 1);
  localparam int RD_W     = $clog2(RD_RAMPS * RAMP_MAX + 1);

  seqStrobe_t       strobe;
  logic [RD_W-1:0]  rdCount;
  logic [CLK_W-1:0] rampLen;

  msadc_ctrl #(
    .RAMP_FAST(RAMP_FAST), .RAMP_SLOW(RAMP_SLOW),
    .RUNUP_LONG(RUNUP_LONG), .RUNUP_SHORT(RUNUP_SHORT),
    .AVG_CONV(AVG_CONV), .RD_RAMPS(RD_RAMPS),
    .CLK_W(CLK_W), .RAMP_W(RAMP_W), .CONV_W(CONV_W), .RD_W(RD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn), .digitsSel(digitsSel),
    .slow50(slow50), .cmpIn(cmpIn), .busy(busy), .integEn(integEn),
    .refUp(refUp), .refDown(refDown), .ovf(ovf), .rdCount(rdCount),
    .rampLen(rampLen), .strobe(strobe)
  );

  msadc_datapath #(
    .CLK_W(CLK_W), .RD_W(RD_W), .ACC_W(ACC_W), .READ_W(READ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdCount(rdCount),
    .rampLen(rampLen), .reading(reading), .done(done)
  );

endmodule

// File: rtl/msadc_checks.sv
module msadc_checks (
  input logic clk,
  input logic rstN,
  input logic startIn,
  input logic busy,
  input logic done,
  input logic integEn,
  input logic refUp,
  input logic refDown
);

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !busy) |=> busy);

  // R4
  integ_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    integEn |-> busy);

  // R5
  ref_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(refUp && refDown));

  // R6
  ref_in_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refUp || refDown) |-> busy);

endmodule

bind msadc_sequencer msadc_checks u_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .busy(busy), .done(done),
  .integEn(integEn), .refUp(refUp), .refDown(refDown)
);

// File: tb/msadc_sequencer_test.sv
`timescale 1ns/1ps
module msadc_sequencer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [1:0]  digitsSel = 2'b00;
  logic        slow50 = 1'b0;
  logic        cmpIn = 1'b0;
  logic        refUp, refDown, integEn, ovf, busy, done;
  logic [23:0] reading;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int lastRead = 0;

  always #2.5 clk = ~clk;

  msadc_sequencer uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .digitsSel(digitsSel),
    .slow50(slow50), .cmpIn(cmpIn), .refUp(refUp), .refDown(refDown),
    .integEn(integEn), .reading(reading), .ovf(ovf), .busy(busy), .done(done)
  );

  // pat: 0 comparator high, 1 low, 2 alternating per ramp (even ramps high)
  // poke: 0 none, 1 start+mode change mid-runup, 2 start on the finishing edge
  typedef struct packed {
    logic [1:0]         dig;
    logic               slow;
    logic [1:0]         pat;
    logic [31:0]        rdLen;
    logic [1:0]         poke;
    logic signed [31:0] expRead;
    logic               expOvf;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{2'b00, 1'b0, 2'd0, 32'd5,    2'd1, 32'sd1025,  1'b0},
    '{2'b00, 1'b1, 2'd1, 32'd7,    2'd0, -32'sd1231, 1'b0},
    '{2'b00, 1'b0, 2'd2, 32'd12,   2'd2, -32'sd12,   1'b0},
    '{2'b01, 1'b0, 2'd2, 32'd20,   2'd0, 32'sd50,    1'b0},
    '{2'b01, 1'b1, 2'd0, 32'd0,    2'd0, 32'sd12564, 1'b0},
    '{2'b00, 1'b0, 2'd0, 32'd5000, 2'd0, 32'sd2940,  1'b1},
    '{2'b00, 1'b0, 2'd0, 32'd1919, 2'd0, 32'sd2939,  1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit patBit(input int pat, input int idx);
    case (pat)
      0:       return 1'b1;
      1:       return 1'b0;
      default: return (idx % 2) == 0;
    endcase
  endfunction

  task automatic runVec(input logic [1:0] dig, input bit slow, input int pat,
                        input int rdLen, input int nConv, input int poke,
                        input int expRead, input bit expOvf, input string req);
    int n, l, lim, last, rdNow;
    bit sign;
    int refBad, integBad, flagBad;
    n = (dig == 2'b00) ? 34 : 349;
    l = slow ? 36 : 30;
    lim = 64 * l;
    last = n * l + ((rdLen < lim) ? rdLen + 1 : lim);
    sign = patBit(pat, n - 1);
    refBad = 0; integBad = 0; flagBad = 0;

    @(negedge clk);
    digitsSel = dig; slow50 = slow; startIn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
    rdNow = int'($signed(reading));
    chk(rdNow == lastRead, "R8", "reading held until done", rdNow, lastRead);

    for (int c = 0; c < nConv; c++) begin
      for (int k = 1; k <= last; k++) begin
        bit cv, expDown;
        if (k <= n * l) cv = patBit(pat, (k - 1) / l);
        else            cv = ((k - n * l) <= rdLen) ? sign : !sign;
        cmpIn = cv;
        if (poke == 1 && c == 0 && k == 100) begin
          startIn = 1'b1; digitsSel = 2'b10; slow50 = !slow;
        end
        if (poke == 2 && c == nConv - 1 && k == last) startIn = 1'b1;
        @(posedge clk);
        @(negedge clk);
        startIn = 1'b0;
        if (k < last) begin
          expDown = (k <= n * l) ? patBit(pat, (k - 1) / l) : sign;
          if (refDown !== expDown || refUp !== !expDown) refBad++;
          if (integEn !== (k < n * l)) integBad++;
          if (done !== 1'b0 || busy !== 1'b1) flagBad++;
        end else if (c < nConv - 1) begin
          if (done !== 1'b0 || busy !== 1'b1) flagBad++;
        end
      end
    end

    rdNow = int'($signed(reading));
    chk(done == 1'b1, "R8", "done at predicted edge", done, 1);
    chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
    chk(rdNow == expRead, req, "reading", rdNow, expRead);
    chk(ovf == expOvf, "R7", "overflow flag", ovf, expOvf);
    chk(!refUp && !refDown && !integEn, "R6", "references off at end",
        {refUp, refDown, integEn}, 0);
    chk(refBad == 0, "R5", "reference trace mismatches", refBad, 0);
    chk(integBad == 0, "R4", "integrator enable trace mismatches", integBad, 0);
    chk(flagBad == 0, (nConv > 1) ? "R9" : "R8", "busy/done during conversion",
        flagBad, 0);
    if (poke == 1)
      chk(rdNow == expRead, "R2 R3", "mid-run start and mode change ignored",
          rdNow, expRead);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", done, 0);
    chk(busy == 1'b0, (poke == 2) ? "R3" : "R8", "idle after finish", busy, 0);
    lastRead = expRead;
  endtask

  initial begin
    startIn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state, start held high during reset
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(reading == '0 && ovf == 1'b0, "R1", "reading/ovf in reset", reading, 0);
    chk(!integEn && !refUp && !refDown, "R1", "analog controls in reset",
        {integEn, refUp, refDown}, 0);
    startIn = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "idle after reset release", busy, 0);

    for (int i = 0; i < 7; i++) begin
      runVec(VECS[i].dig, VECS[i].slow, int'(VECS[i].pat), int'(VECS[i].rdLen), 1,
             int'(VECS[i].poke), int'(VECS[i].expRead), VECS[i].expOvf, "R6 R8");
    end

    // R9: ten summed conversions, each 349*30 + 3 = 10473
    runVec(2'b10, 1'b0, 0, 3, 10, 0, 104730, 1'b0, "R9");

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule